// File: doc/BRIEF.md
# Dual-Byte 8B/10B Transmit Encoder

This block turns a parallel transmit word into 8B/10B code groups and shifts the result out one bit per clock, least-significant bit first. Each word carries a number of byte lanes (two by default). Each lane has its own data/control flag, held in a reserved bit above the data bytes. The lanes are encoded from the lowest to the highest. The running disparity left by one lane is the input disparity of the next, and the disparity left by the top lane carries into the following word.

A two-bit mode input is sampled together with each word and selects one of three paths. The raw path passes all bus bits through unencoded. The half-rate path encodes only the lowest lane into a single 10-bit group. The full path encodes every lane. The block pulls a new word each time the serial shifter runs empty and signals this with a one-cycle take strobe. It also presents the whole encoded word in parallel, with an error flag for control requests that name no defined control code.

Top module: `enc8b10b_tx`

## Requirements
- R1: While reset is held and immediately after it, code_o is 0, rd_o is 0 (0 = negative disparity, 1 = positive), kerr_o is 0, serial_o is 0 and take_o is 1.
- R2: With mode_i = 2'b00 (raw), code_o equals the word exactly as presented, rd_o keeps its previous value and kerr_o is 0.
- R3: After a take cycle, serial_o presents code_o bit 0 in the next cycle, then one bit per clock in ascending order. Each full or raw word sends 20 bits.
- R4: With mode_i = 2'b10 or 2'b11 (full), bits 7:0 with flag bit 16 are encoded into code_o[9:0], and bits 15:8 with flag bit 17 are encoded into code_o[19:10]. Bits 18 and 19 have no effect. Within a group, code bit 0 is a, bits 1-5 are b,c,d,e,i and bits 6-9 are f,g,h,j.
- R5: A lane with flag 0 produces the standard data code group for its byte at the current disparity. Examples: byte 0xB5 gives 10'h155 at either disparity, and byte 0x00 gives 10'h0B9 at negative disparity.
- R6: The lowest lane uses the disparity of the previous word, and each higher lane uses the disparity left by the lane below it. A group starting at negative disparity has 5 or 6 ones, and one starting at positive disparity has 4 or 5 ones.
- R7: A lane with flag 1 and one of the twelve control bytes (0x1C,0x3C,0x5C,0x7C,0x9C,0xBC,0xDC,0xFC,0xF7,0xFB,0xFD,0xFE) produces the standard control code group. Flag 1 with byte 0xBC at negative disparity gives 10'h17C.
- R8: A lane with flag 1 and any other byte sets kerr_o for that word and is encoded as the data code group of the same byte.
- R9: With mode_i = 2'b01 (half rate), only bits 7:0 and flag bit 16 are used. code_o[19:10] is 0, 10 serial bits are sent, and all other bus bits have no effect.
- R10: take_o is high for exactly one cycle per word. The word and mode are sampled at the clock edge that ends that cycle, and the next take follows 20 cycles later (10 in half rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 20 | Parallel transmit word: data bytes, per-lane flags, spare bits |
| mode_i | input | 2 | 00 raw, 01 half rate, 10/11 full encode |
| take_o | output | 1 | Word and mode are sampled at the end of this cycle |
| code_o | output | 20 | Encoded (or raw) word last taken |
| serial_o | output | 1 | Serial bit stream, LSB first |
| kerr_o | output | 1 | Last taken word asked for an undefined control code |
| rd_o | output | 1 | Running disparity after the last taken word, 1 = positive |

## Verification
The assertions assume that word_i and mode_i are stable around the clock edge that closes a take cycle. They also assume that mode_i takes one of its four values at that edge, so the sampled word is the one the properties compare with. The bench drives new inputs only on the falling edge of a cycle where take_o is high and holds them until the next take. Control flags in the random stimulus mostly point at one of the twelve defined control bytes. Undefined requests are injected on purpose and are checked against the data-group fallback.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

   typedef enum logic [1:0] {
      MODE_RAW   = 2'b00,
      MODE_HALF  = 2'b01,
      MODE_FULLA = 2'b10,
      MODE_FULLB = 2'b11
   } tx_mode_e;

   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned GROUP_W = 10;

   // 5b/6b groups at negative disparity, written abcdei with a as MSB
   function automatic logic [5:0] grp6_neg(input logic [4:0] x);
      case (x)
         5'd0:  grp6_neg = 6'b100111;
         5'd1:  grp6_neg = 6'b011101;
         5'd2:  grp6_neg = 6'b101101;
         5'd3:  grp6_neg = 6'b110001;
         5'd4:  grp6_neg = 6'b110101;
         5'd5:  grp6_neg = 6'b101001;
         5'd6:  grp6_neg = 6'b011001;
         5'd7:  grp6_neg = 6'b111000;
         5'd8:  grp6_neg = 6'b111001;
         5'd9:  grp6_neg = 6'b100101;
         5'd10: grp6_neg = 6'b010101;
         5'd11: grp6_neg = 6'b110100;
         5'd12: grp6_neg = 6'b001101;
         5'd13: grp6_neg = 6'b101100;
         5'd14: grp6_neg = 6'b011100;
         5'd15: grp6_neg = 6'b010111;
         5'd16: grp6_neg = 6'b011011;
         5'd17: grp6_neg = 6'b100011;
         5'd18: grp6_neg = 6'b010011;
         5'd19: grp6_neg = 6'b110010;
         5'd20: grp6_neg = 6'b001011;
         5'd21: grp6_neg = 6'b101010;
         5'd22: grp6_neg = 6'b011010;
         5'd23: grp6_neg = 6'b111010;
         5'd24: grp6_neg = 6'b110011;
         5'd25: grp6_neg = 6'b100110;
         5'd26: grp6_neg = 6'b010110;
         5'd27: grp6_neg = 6'b110110;
         5'd28: grp6_neg = 6'b001110;
         5'd29: grp6_neg = 6'b101110;
         5'd30: grp6_neg = 6'b011110;
         default: grp6_neg = 6'b101011;
      endcase
   endfunction

   // 3b/4b groups at negative disparity, fghj with f as MSB
   function automatic logic [3:0] grp4_neg(input logic [2:0] y, input logic alt7);
      case (y)
         3'd0: grp4_neg = 4'b1011;
         3'd1: grp4_neg = 4'b1001;
         3'd2: grp4_neg = 4'b0101;
         3'd3: grp4_neg = 4'b1100;
         3'd4: grp4_neg = 4'b1101;
         3'd5: grp4_neg = 4'b1010;
         3'd6: grp4_neg = 4'b0110;
         default: grp4_neg = alt7 ? 4'b0111 : 4'b1110;
      endcase
   endfunction

   // trailing nibble of the x=28 control groups at negative disparity
   function automatic logic [3:0] grp4_k28(input logic [2:0] y);
      case (y)
         3'd0: grp4_k28 = 4'b0100;
         3'd1: grp4_k28 = 4'b1001;
         3'd2: grp4_k28 = 4'b0101;
         3'd3: grp4_k28 = 4'b0011;
         3'd4: grp4_k28 = 4'b0010;
         3'd5: grp4_k28 = 4'b1010;
         3'd6: grp4_k28 = 4'b0110;
         default: grp4_k28 = 4'b1000;
      endcase
   endfunction

endpackage

// File: rtl/enc8b10b_lane.sv
module enc8b10b_lane
   import enc8b10b_pkg::*;
(
   input  logic [BYTE_W-1:0]  byte_i,
   input  logic               kflag_i,
   input  logic               rd_i,
   output logic [GROUP_W-1:0] code_o,
   output logic               rd_o,
   output logic               kerr_o
);

   logic [4:0] x;
   logic [2:0] y;
   logic       is_k28, is_kx7, use_k28, use_alt, rd_mid;
   logic [5:0] g6;
   logic [3:0] g4;
   logic [9:0] msb_first;

   always_comb begin
      x       = byte_i[4:0];
      y       = byte_i[7:5];
      is_k28  = (x == 5'd28);
      is_kx7  = (y == 3'd7) && ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30));
      kerr_o  = kflag_i && !(is_k28 || is_kx7);
      use_k28 = kflag_i && is_k28;

      // six-bit sub-block
      g6 = use_k28 ? 6'b001111 : grp6_neg(x);
      if (rd_i && (($countones(g6) != 3) || (x == 5'd7 && !use_k28)))
         g6 = ~g6;
      if ($countones(g6) > 3)       rd_mid = 1'b1;
      else if ($countones(g6) < 3)  rd_mid = 1'b0;
      else                          rd_mid = rd_i;

      // four-bit sub-block
      use_alt = (y == 3'd7) &&
                ((kflag_i && is_kx7) ||
                 (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                 ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
      if (use_k28) begin
         g4 = rd_i ? ~grp4_k28(y) : grp4_k28(y);
      end else begin
         g4 = grp4_neg(y, use_alt);
         if (rd_mid && (($countones(g4) != 2) || (y == 3'd3)))
            g4 = ~g4;
      end

      msb_first = {g6, g4};
      for (int i = 0; i < GROUP_W; i++)
         code_o[i] = msb_first[GROUP_W-1-i];

      if ($countones(msb_first) > 5)       rd_o = 1'b1;
      else if ($countones(msb_first) < 5)  rd_o = 1'b0;
      else                                 rd_o = rd_i;
   end

endmodule

// File: rtl/enc8b10b_shifter.sv
module enc8b10b_shifter #(
   parameter int unsigned WIDTH = 20,
   localparam int unsigned CW   = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] data_i,
   input  logic [CW-1:0]    len_i,
   output logic             empty_o,
   output logic             ser_o
);

   logic [WIDTH-1:0] sh_q;
   logic [CW-1:0]    left_q;

   assign empty_o = (left_q == '0);
   assign ser_o   = sh_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (empty_o) begin
         sh_q   <= data_i;
         left_q <= len_i - 1'b1;
      end else begin
         sh_q   <= sh_q >> 1;
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/enc8b10b_tx.sv
module enc8b10b_tx
   import enc8b10b_pkg::*;
#(
   parameter int unsigned N_LANES = 2,
   localparam int unsigned WORD_W = N_LANES * GROUP_W,
   localparam int unsigned FLAG_LO = N_LANES * BYTE_W,
   localparam int unsigned CW     = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic [1:0]        mode_i,
   output logic              take_o,
   output logic [WORD_W-1:0] code_o,
   output logic              serial_o,
   output logic              kerr_o,
   output logic              rd_o
);

   if (N_LANES < 1) begin : g_bad_lanes
      $error("enc8b10b_tx: N_LANES must be at least 1");
   end

   logic [N_LANES:0]   rd_c;
   logic [GROUP_W-1:0] lane_code [N_LANES];
   logic [N_LANES-1:0] lane_err;
   logic [WORD_W-1:0]  full_code, nxt_code;
   logic [CW-1:0]      nxt_len;
   logic               nxt_rd, nxt_err;
   tx_mode_e           mode;

   assign rd_c[0] = rd_o;
   assign mode    = tx_mode_e'(mode_i);

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      enc8b10b_lane u_lane (
         .byte_i (word_i[l*BYTE_W +: BYTE_W]),
         .kflag_i(word_i[FLAG_LO + l]),
         .rd_i   (rd_c[l]),
         .code_o (lane_code[l]),
         .rd_o   (rd_c[l+1]),
         .kerr_o (lane_err[l])
      );
   end

   always_comb begin
      for (int l = 0; l < N_LANES; l++)
         full_code[l*GROUP_W +: GROUP_W] = lane_code[l];
      case (mode)
         MODE_RAW: begin
            nxt_code = word_i;
            nxt_rd   = rd_o;
            nxt_err  = 1'b0;
            nxt_len  = CW'(WORD_W);
         end
         MODE_HALF: begin
            nxt_code = WORD_W'(lane_code[0]);
            nxt_rd   = rd_c[1];
            nxt_err  = lane_err[0];
            nxt_len  = CW'(GROUP_W);
         end
         default: begin
            nxt_code = full_code;
            nxt_rd   = rd_c[N_LANES];
            nxt_err  = |lane_err;
            nxt_len  = CW'(WORD_W);
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_o <= '0;
         rd_o   <= 1'b0;
         kerr_o <= 1'b0;
      end else if (take_o) begin
         code_o <= nxt_code;
         rd_o   <= nxt_rd;
         kerr_o <= nxt_err;
      end
   end

   enc8b10b_shifter #(.WIDTH(WORD_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_i (nxt_code),
      .len_i  (nxt_len),
      .empty_o(take_o),
      .ser_o  (serial_o)
   );

endmodule

// File: rtl/enc8b10b_tx_chk.sv
module enc8b10b_tx_chk #(
   parameter int unsigned N_LANES = 2,
   localparam int unsigned WORD_W = N_LANES * 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] word_i,
   input logic [1:0]        mode_i,
   input logic              take_o,
   input logic [WORD_W-1:0] code_o,
   input logic              kerr_o,
   input logic              rd_o
);

   // R2: raw words pass unchanged
   a_r2_raw_copy: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && mode_i == 2'b00 |=> code_o == $past(word_i));

   // R2: raw words leave disparity alone and raise no error
   a_r2_raw_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && mode_i == 2'b00 |=> rd_o == $past(rd_o) && !kerr_o);

   // R6: group from negative disparity carries 5 or 6 ones
   a_r6_group_from_neg: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && mode_i != 2'b00 && !rd_o |=>
         $countones(code_o[9:0]) >= 5 && $countones(code_o[9:0]) <= 6);

   // R6: group from positive disparity carries 4 or 5 ones
   a_r6_group_from_pos: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && mode_i != 2'b00 && rd_o |=>
         $countones(code_o[9:0]) >= 4 && $countones(code_o[9:0]) <= 5);

   // R10: take strobe lasts one cycle
   a_r10_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> !take_o);

   if (N_LANES > 1) begin : g_upper
      // R9: half rate leaves upper groups at zero
      a_r9_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         take_o && mode_i == 2'b01 |=> code_o[WORD_W-1:10] == '0);
   end

endmodule

bind enc8b10b_tx enc8b10b_tx_chk #(.N_LANES(N_LANES)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .word_i(word_i),
   .mode_i(mode_i),
   .take_o(take_o),
   .code_o(code_o),
   .kerr_o(kerr_o),
   .rd_o  (rd_o)
);

// File: tb/tb_enc8b10b_tx.sv
module tb_enc8b10b_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] word_i = '0;
   logic [1:0]  mode_i = 2'b00;
   logic        take_o, serial_o, kerr_o, rd_o;
   logic [19:0] code_o;

   int n_chk = 0;
   int n_bad = 0;
   logic m_rd = 1'b0;
   bit done = 1'b0;

   enc8b10b_tx dut (
      .clk(clk), .rst_n(rst_n), .word_i(word_i), .mode_i(mode_i),
      .take_o(take_o), .code_o(code_o), .serial_o(serial_o),
      .kerr_o(kerr_o), .rd_o(rd_o)
   );

   always #10 clk = ~clk;

   function automatic logic [5:0] t6(input logic [4:0] x);
      logic [5:0] r;
      case (x)
         0: r = 6'b100111;  1: r = 6'b011101;  2: r = 6'b101101;  3: r = 6'b110001;
         4: r = 6'b110101;  5: r = 6'b101001;  6: r = 6'b011001;  7: r = 6'b111000;
         8: r = 6'b111001;  9: r = 6'b100101; 10: r = 6'b010101; 11: r = 6'b110100;
        12: r = 6'b001101; 13: r = 6'b101100; 14: r = 6'b011100; 15: r = 6'b010111;
        16: r = 6'b011011; 17: r = 6'b100011; 18: r = 6'b010011; 19: r = 6'b110010;
        20: r = 6'b001011; 21: r = 6'b101010; 22: r = 6'b011010; 23: r = 6'b111010;
        24: r = 6'b110011; 25: r = 6'b100110; 26: r = 6'b010110; 27: r = 6'b110110;
        28: r = 6'b001110; 29: r = 6'b101110; 30: r = 6'b011110; default: r = 6'b101011;
      endcase
      return r;
   endfunction

   function automatic bit kvalid(input logic [7:0] b);
      return (b[4:0] == 5'd28) || b == 8'hF7 || b == 8'hFB || b == 8'hFD || b == 8'hFE;
   endfunction

   // returns {rd_after, group LSB-first}
   function automatic logic [10:0] ref_enc(input logic [7:0] b, input logic k, input logic rd);
      logic [5:0] s6; logic [3:0] s4; logic [9:0] m; logic r6, kk; logic [10:0] out;
      kk = k && kvalid(b);
      if (kk && b[4:0] == 5'd28) begin
         case (b[7:5])
            0: s4 = 4'b0100; 1: s4 = 4'b1001; 2: s4 = 4'b0101; 3: s4 = 4'b0011;
            4: s4 = 4'b0010; 5: s4 = 4'b1010; 6: s4 = 4'b0110; default: s4 = 4'b1000;
         endcase
         m = {6'b001111, s4};
         if (rd) m = ~m;
      end else begin
         s6 = t6(b[4:0]);
         if (rd && ($countones(s6) != 3 || b[4:0] == 5'd7)) s6 = ~s6;
         r6 = ($countones(s6) == 3) ? rd : ($countones(s6) > 3);
         case (b[7:5])
            0: s4 = 4'b1011; 1: s4 = 4'b1001; 2: s4 = 4'b0101; 3: s4 = 4'b1100;
            4: s4 = 4'b1101; 5: s4 = 4'b1010; 6: s4 = 4'b0110;
            default: s4 = (kk || (!r6 && (b[4:0] == 17 || b[4:0] == 18 || b[4:0] == 20)) ||
                           (r6 && (b[4:0] == 11 || b[4:0] == 13 || b[4:0] == 14))) ? 4'b0111 : 4'b1110;
         endcase
         if (r6 && ($countones(s4) != 2 || b[7:5] == 3'd3)) s4 = ~s4;
         m = {s6, s4};
      end
      for (int i = 0; i < 10; i++) out[i] = m[9-i];
      out[10] = ($countones(m) == 5) ? rd : ($countones(m) > 5);
      return out;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drives one word at a falling edge where take_o is high, then checks it
   task automatic send(input logic [19:0] w, input logic [1:0] md);
      logic [19:0] e_code; logic e_err, e_rd; logic [10:0] r0, r1; int len; int badbits;
      string rq;
      check("R10 take before word", take_o, 1);
      e_rd = m_rd;
      if (md == 2'b00) begin
         e_code = w; e_err = 0; len = 20; rq = "R2";
      end else if (md == 2'b01) begin
         r0 = ref_enc(w[7:0], w[16], m_rd);
         e_code = {10'd0, r0[9:0]}; e_err = w[16] && !kvalid(w[7:0]); e_rd = r0[10]; len = 10; rq = "R9";
      end else begin
         r0 = ref_enc(w[7:0], w[16], m_rd);
         r1 = ref_enc(w[15:8], w[17], r0[10]);
         e_code = {r1[9:0], r0[9:0]};
         e_err = (w[16] && !kvalid(w[7:0])) || (w[17] && !kvalid(w[15:8]));
         e_rd = r1[10]; len = 20; rq = "R4/R5/R6/R7";
      end
      word_i = w; mode_i = md;
      @(posedge clk);
      @(negedge clk);
      check({rq, " code"}, code_o, e_code);
      check("R8 kerr", kerr_o, e_err);
      check("R6 rd", rd_o, e_rd);
      m_rd = e_rd;
      badbits = 0;
      for (int k = 0; k < len; k++) begin
         if (k > 0) @(negedge clk);
         if (serial_o !== e_code[k]) badbits++;
         if (take_o !== (k == len - 1)) badbits++;
      end
      check("R3/R10 serial order and take spacing", badbits, 0);
   endtask

   initial begin
      logic [7:0] kl [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                              8'hF7, 8'hFB, 8'hFD, 8'hFE};
      logic [19:0] w; logic [1:0] md; int unsigned seed;
      seed = 32'd2024;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset values
      check("R1 code", code_o, 0);
      check("R1 rd", rd_o, 0);
      check("R1 kerr", kerr_o, 0);
      check("R1 serial", serial_o, 0);
      check("R1 take", take_o, 1);
      rst_n = 1'b1;

      // R7/R5: K28.5 low, D21.5 high from negative disparity
      send(20'h1B5BC, 2'b10);
      check("R7 K28.5 literal", code_o[9:0], 10'h17C);
      check("R5 D21.5 literal", code_o[19:10], 10'h155);
      // R2: raw word keeps rd positive
      send(20'hABCDE, 2'b00);
      check("R2 rd kept", rd_o, 1);
      // R4: bits 18,19 ignored
      send(20'hCB5BC, 2'b11);
      // R9: half rate with junk upper bits, D0.0
      send(20'hEFF00 & 20'hEFF00, 2'b01);
      send(20'h4FF00, 2'b01);
      // R8: undefined control requests
      send(20'h10009, 2'b01);
      send(20'h30A09, 2'b10);
      // R5: D0.0 at negative disparity
      while (m_rd) send(20'h000BC | 20'h10000, 2'b01);
      send(20'h00000, 2'b01);
      check("R5 D0.0 literal", code_o[9:0], 10'h0B9);

      for (int n = 0; n < 400; n++) begin
         w = 20'($urandom);
         md = 2'($urandom);
         if (w[16] && ($urandom % 8 != 0)) w[7:0] = kl[$urandom % 12];
         if (w[17] && ($urandom % 8 != 0)) w[15:8] = kl[$urandom % 12];
         send(w, md);
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule